// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps real time as a single long count. A fraction field advances once for each pulse of a slow time-base strobe, nominally 32.768 kHz. When the fraction wraps, it carries into a seconds field. By default the fraction is 15 bits and the seconds field is 32 bits, which gives 47 bits in all. The strobe is a one-cycle enable that is already synchronous to the register clock.

Software controls the block through a small register port. It can read or load the seconds and the fraction, start or stop the count, clear the status flags, and program a seconds alarm. The alarm is compared only when the seconds field steps forward. A match sets a sticky flag, and that flag drives an interrupt when the alarm interrupt is enabled. If the counter is about to step past its largest value, it stops in place and reports an overflow until software clears it.

Register offsets (byte addresses):

| Offset | Register |
|---|---|
| 0x00 | seconds |
| 0x04 | fraction (low bits) |
| 0x08 | control |
| 0x0C | status |
| 0x10 | interrupt enable |
| 0x14 | alarm seconds |

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset the seconds, fraction, control, status and interrupt enable registers read 0. The alarm register reads all ones, and `irq_o` is low.
- R2: The count advances only while control bit 3 (run) is 1. With run at 0, strobes leave the fraction unchanged.
- R3: Each strobe while running adds one to the fraction. A strobe that finds the fraction all ones sets the fraction to 0 and adds one to the seconds.
- R4: A write to offset 0x00 loads the seconds and clears the fraction. A write to offset 0x04 loads only the fraction. A register write in the same cycle as a strobe wins, and that strobe is dropped.
- R5: A strobe that finds both fields all ones sets status bit 2 (overflow) and leaves both fields unchanged. While status bit 2 is 1, strobes have no effect, even after software loads new field values.
- R6: Writing 1 to status bit 2 clears it, and counting resumes on the next strobe.
- R7: Status bit 4 (alarm) is set when the seconds field steps to the value in the alarm register. Loading the seconds with that value through a write does not set status bit 4.
- R8: Status bit 4 stays set until software writes 1 to it. Writing 0 to it leaves it set.
- R9: `irq_o` is high exactly when status bit 4 and interrupt-enable bit 4 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle time-base strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The counter is driven in several ways, and each one separates a different fault:
- Strobes with run low catch a counter that ignores the run bit.
- Short bursts from a loaded fraction show whether the carry happens on the right strobe.
- A write in the same cycle as a strobe shows which of the two has priority.
- Stepping into the largest value shows whether the counter holds or wraps, and whether a later load can restart it before the flag is cleared.

For the alarm, the bench loads the seconds directly to the alarm value and separately steps the seconds into it. This tells a compare made on every cycle apart from one made only when the seconds step. Separate writes of 0 and 1 to the flag check that it is sticky and clears only by write-one.

// File: rtl/sec_alarm_rtc_pkg.sv
package sec_alarm_rtc_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] ADR_SEC  = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_FRAC = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_IEN  = 5'h10;
    localparam logic [ADDR_W-1:0] ADR_ALRM = 5'h14;

    localparam int CTRL_RUN_BIT = 3;
    localparam int STAT_OVF_BIT = 2;
    localparam int STAT_ALM_BIT = 4;
    localparam int IEN_ALM_BIT  = 4;
endpackage

// File: rtl/sar_frac.sv
module sar_frac #(
    parameter int W = 15
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] frac_o,
    output logic         full_o
);
    logic [W-1:0] frac_d, frac_q;

    always_comb begin
        frac_d = frac_q;
        if (load_i)      frac_d = load_val_i;
        else if (step_i) frac_d = frac_q + W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) frac_q <= '0;
        else         frac_q <= frac_d;
    end

    assign frac_o = frac_q;
    assign full_o = &frac_q;
endmodule

// File: rtl/sar_secs.sv
module sar_secs #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] sec_o,
    output logic [W-1:0] next_o,
    output logic         full_o
);
    logic [W-1:0] sec_d, sec_q;

    assign next_o = sec_q + W'(1);

    always_comb begin
        sec_d = sec_q;
        if (load_i)      sec_d = load_val_i;
        else if (step_i) sec_d = next_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sec_q <= '0;
        else         sec_q <= sec_d;
    end

    assign sec_o  = sec_q;
    assign full_o = &sec_q;
endmodule

// File: rtl/sar_match.sv
module sar_match #(
    parameter int W = 32
) (
    input  logic         step_i,
    input  logic [W-1:0] next_sec_i,
    input  logic [W-1:0] alarm_i,
    output logic         hit_o
);
    // Compared only on a seconds step, against the value being entered
    assign hit_o = step_i && (next_sec_i == alarm_i);
endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
    import sec_alarm_rtc_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic             run;
        logic             ovf;
        logic             alm;
        logic             alm_ie;
        logic [SEC_W-1:0] alarm;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              wr_sec, wr_frac, wr_ctrl, wr_stat, wr_ien, wr_alrm;
    logic              advance, ovf_evt, frac_step, sec_step, hit;
    logic              frac_full, sec_full;
    logic [FRAC_W-1:0] frac_val, frac_load_val;
    logic [SEC_W-1:0]  sec_val, sec_next;

    assign wr_sec  = wr_en_i && (addr_i == ADR_SEC);
    assign wr_frac = wr_en_i && (addr_i == ADR_FRAC);
    assign wr_ctrl = wr_en_i && (addr_i == ADR_CTRL);
    assign wr_stat = wr_en_i && (addr_i == ADR_STAT);
    assign wr_ien  = wr_en_i && (addr_i == ADR_IEN);
    assign wr_alrm = wr_en_i && (addr_i == ADR_ALRM);

    // A field load in the same cycle drops the strobe
    assign advance   = tick_i && st_q.run && !st_q.ovf && !wr_sec && !wr_frac;
    assign ovf_evt   = advance && frac_full && sec_full;
    assign frac_step = advance && !ovf_evt;
    assign sec_step  = frac_step && frac_full;

    assign frac_load_val = wr_sec ? '0 : wdata_i[FRAC_W-1:0];

    sar_frac #(.W(FRAC_W)) u_frac (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (frac_step),
        .load_i     (wr_sec || wr_frac),
        .load_val_i (frac_load_val),
        .frac_o     (frac_val),
        .full_o     (frac_full)
    );

    sar_secs #(.W(SEC_W)) u_secs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (sec_step),
        .load_i     (wr_sec),
        .load_val_i (wdata_i[SEC_W-1:0]),
        .sec_o      (sec_val),
        .next_o     (sec_next),
        .full_o     (sec_full)
    );

    sar_match #(.W(SEC_W)) u_match (
        .step_i     (sec_step),
        .next_sec_i (sec_next),
        .alarm_i    (st_q.alarm),
        .hit_o      (hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.run    = wdata_i[CTRL_RUN_BIT];
        if (wr_ien)  st_d.alm_ie = wdata_i[IEN_ALM_BIT];
        if (wr_alrm) st_d.alarm  = wdata_i[SEC_W-1:0];
        // Hardware events take priority over a write-one clear
        if (ovf_evt)                              st_d.ovf = 1'b1;
        else if (wr_stat && wdata_i[STAT_OVF_BIT]) st_d.ovf = 1'b0;
        if (hit)                                  st_d.alm = 1'b1;
        else if (wr_stat && wdata_i[STAT_ALM_BIT]) st_d.alm = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.alarm  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_SEC:  rdata_o = REG_W'(sec_val);
            ADR_FRAC: rdata_o = REG_W'(frac_val);
            ADR_CTRL: rdata_o[CTRL_RUN_BIT] = st_q.run;
            ADR_STAT: begin
                rdata_o[STAT_OVF_BIT] = st_q.ovf;
                rdata_o[STAT_ALM_BIT] = st_q.alm;
            end
            ADR_IEN:  rdata_o[IEN_ALM_BIT] = st_q.alm_ie;
            ADR_ALRM: rdata_o = REG_W'(st_q.alarm);
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.alm && st_q.alm_ie;
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic              run_i,
    input logic              ovf_i,
    input logic              alm_i,
    input logic              alm_ie_i,
    input logic              irq_i,
    input logic [SEC_W-1:0]  sec_i,
    input logic [FRAC_W-1:0] frac_i,
    input logic [SEC_W-1:0]  alarm_i
);
    // R2
    halted_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!run_i) && !$past(wr_en_i)) |-> ($stable(frac_i) && $stable(sec_i)));

    // R3
    frac_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(run_i && !ovf_i && tick_i && !wr_en_i) && !ovf_i)
        |-> (frac_i == FRAC_W'($past(frac_i) + FRAC_W'(1))));

    // R5
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ovf_i) && !$past(wr_en_i)) |-> ($stable(frac_i) && $stable(sec_i)));

    // R7
    alarm_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(alm_i) && !$past(wr_en_i)) |-> (sec_i == alarm_i));

    // R9
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (alm_i && alm_ie_i));
endmodule

bind sec_alarm_rtc sar_checker #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_en_i  (wr_en_i),
    .run_i    (st_q.run),
    .ovf_i    (st_q.ovf),
    .alm_i    (st_q.alm),
    .alm_ie_i (st_q.alm_ie),
    .irq_i    (irq_o),
    .sec_i    (sec_val),
    .frac_i   (frac_val),
    .alarm_i  (st_q.alarm)
);

// File: tb/sec_alarm_rtc_tb.sv
module sec_alarm_rtc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [4:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    sec_alarm_rtc u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .tick_i  (tick),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    localparam logic [4:0] A_SEC = 5'h00, A_FRAC = 5'h04, A_CTRL = 5'h08,
                           A_STAT = 5'h0C, A_IEN = 5'h10, A_ALRM = 5'h14;

    task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d, input logic t);
        @(posedge clk);
        #1;
        wr_en = we; addr = a; wdata = d; tick = t;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b1);
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        cyc(1'b0, a, '0, 1'b0);
        it.is_irq = 1'b0; it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        cyc(1'b0, '0, '0, 1'b0);
        it.is_irq = 1'b1; it.a = '0; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares mid-cycle, away from the active edge
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        expect_reg(A_SEC,  32'h0, "R1 seconds");
        expect_reg(A_FRAC, 32'h0, "R1 fraction");
        expect_reg(A_CTRL, 32'h0, "R1 control");
        expect_reg(A_STAT, 32'h0, "R1 status");
        expect_reg(A_IEN,  32'h0, "R1 irq enable");
        expect_reg(A_ALRM, 32'hFFFF_FFFF, "R1 alarm");
        expect_irq(1'b0, "R1 irq");

        // R2 strobes ignored while stopped
        ticks(5);
        expect_reg(A_FRAC, 32'h0, "R2 stopped fraction");

        // R3 counting and carry
        wr(A_CTRL, 32'h8);
        ticks(3);
        expect_reg(A_FRAC, 32'h3, "R3 fraction count");
        wr(A_FRAC, 32'h7FFE);
        ticks(1);
        expect_reg(A_FRAC, 32'h7FFF, "R3 fraction before carry");
        ticks(1);
        expect_reg(A_FRAC, 32'h0, "R3 fraction wrap");
        expect_reg(A_SEC,  32'h1, "R3 seconds carry");

        // R4 loads and write priority
        ticks(3);
        wr(A_SEC, 32'd100);
        expect_reg(A_FRAC, 32'h0, "R4 seconds write clears fraction");
        expect_reg(A_SEC,  32'd100, "R4 seconds load");
        wr(A_FRAC, 32'h1234);
        expect_reg(A_SEC,  32'd100, "R4 fraction write keeps seconds");
        expect_reg(A_FRAC, 32'h1234, "R4 fraction load");
        cyc(1'b1, A_FRAC, 32'h5, 1'b1);
        expect_reg(A_FRAC, 32'h5, "R4 write beats strobe");

        // R7 alarm compare only on stepping
        wr(A_ALRM, 32'd101);
        wr(A_SEC, 32'd101);
        expect_reg(A_STAT, 32'h0, "R7 load does not match");
        wr(A_SEC, 32'd100);
        wr(A_FRAC, 32'h7FFF);
        ticks(1);
        expect_reg(A_SEC,  32'd101, "R3 seconds step");
        expect_reg(A_STAT, 32'h10, "R7 alarm on step");
        expect_irq(1'b0, "R9 irq masked");
        wr(A_IEN, 32'h10);
        expect_irq(1'b1, "R9 irq raised");

        // R8 sticky flag
        wr(A_STAT, 32'h0);
        expect_reg(A_STAT, 32'h10, "R8 write zero keeps flag");
        wr(A_STAT, 32'h10);
        expect_reg(A_STAT, 32'h0, "R8 write one clears flag");
        expect_irq(1'b0, "R9 irq drops");

        // R5 overflow hold
        wr(A_SEC, 32'hFFFF_FFFF);
        wr(A_FRAC, 32'h7FFE);
        ticks(2);
        expect_reg(A_STAT, 32'h04, "R5 overflow flag");
        expect_reg(A_SEC,  32'hFFFF_FFFF, "R5 seconds held");
        expect_reg(A_FRAC, 32'h7FFF, "R5 fraction held");
        ticks(3);
        expect_reg(A_FRAC, 32'h7FFF, "R5 strobes ignored");
        wr(A_SEC, 32'd5);
        ticks(2);
        expect_reg(A_FRAC, 32'h0, "R5 held after reload");

        // R6 clear resumes
        wr(A_STAT, 32'h04);
        expect_reg(A_STAT, 32'h0, "R6 overflow cleared");
        ticks(2);
        expect_reg(A_FRAC, 32'h2, "R6 counting resumes");
        expect_reg(A_SEC,  32'd5, "R6 seconds kept");

        // R2 stop mid-run
        wr(A_CTRL, 32'h0);
        ticks(4);
        expect_reg(A_FRAC, 32'h2, "R2 stop holds fraction");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule